// File: doc/BRIEF.md
# Relocatable I/O Configuration Register Window

This block holds a 64-byte window of configuration registers in I/O space whose base address is not fixed by hardware. After a system reset, only one 16-bit bootstrap register answers, at the fixed I/O address 02EAh. Boot code writes the desired window base to that port once. The block latches the value with its low six bits cleared, so the window always starts on a 64-byte boundary. From then on the bootstrap port ignores all traffic until the next reset, and the window answers at its new location.

Inside the window, every dword except the last is plain byte-writable storage that reads back what was last written. The last dword (offset 3Ch) is special. Its two low bytes return an identification byte and a revision byte, both set by parameters. Its two high bytes (offset 3Eh) return the programmed base, so software can find the window. Nothing in that dword can be written through the window.

The slave is a simple 32-bit I/O port. It has a byte address, per-lane byte enables, and read and write strobes. Read data and a hit flag are produced combinationally in the cycle of the access, so a bus mux outside the block can choose this block's data. Writes take effect at the clock edge that ends the access cycle.

Top module: `cfgwin_io`

## Requirements
- R1: After reset the block is unprogrammed. A read strobe to the dword holding port 02EAh (address bits 15:2 equal to 02E8h>>2) with either byte lane 2 or 3 enabled gives hit=1 and read data 0x0000FFFF: the base (still zero) sits in lanes 3:2 and all ones sit in lanes 1:0.
- R2: While unprogrammed, an access to any dword other than the bootstrap dword gives hit=0 and read data all ones, and a write there changes no storage.
- R3: The first write to the bootstrap dword that enables both lanes 3 and 2 (byte enables 4'b11xx) programs the block. It latches wdata[31:16] as the base with bits 5:0 forced to zero.
- R4: Once programmed, the base never changes until reset. The bootstrap port no longer decodes, so accesses to it miss unless they fall inside the window, where they reach window storage.
- R5: hit is 1 only in a cycle with a read or write strobe whose address bits 15:6 equal the programmed base bits 15:6 (or a bootstrap decode per R1/R9). When hit is 0, or no read is in progress, read data is all ones.
- R6: Window dwords at offsets 00h through 38h read back the last written value, reset to zero, and a write changes only the byte lanes whose enable bit is set.
- R7: A read of window offset 3Ch returns {base[15:0], REV_BYTE, ID_BYTE} (lanes 3:2 base, lane 1 revision, lane 0 ID). Writes to that dword are discarded.
- R8: Asserting the synchronous reset returns the block to the unprogrammed state and clears all window storage.
- R9: A write to the bootstrap dword that enables only one of lanes 3 and 2 gets hit=1 but does not program the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous system reset |
| io_addr | input | 16 | I/O byte address; bits 15:2 select the dword |
| io_be | input | 4 | Byte-lane enables for the 32-bit data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, all ones when not hit or not reading |
| hit | output | 1 | Access decoded by this block in this cycle |

## Verification
The assertions check, on every cycle, the properties that do not depend on history. These are: idle cycles and misses return all ones with no hit, unprogrammed accesses away from the bootstrap dword miss, the latched base is 64-byte aligned and never changes once programmed, offset 3Ch always shows the base with the ID and revision bytes, and reset clears the programmed state. Only the bench's scenarios can show the properties that need a sequence of accesses. These are: storage reads back what earlier byte-masked writes left, a write made before programming leaves no trace, a partial bootstrap write leaves the block unprogrammed, and the port is deaf after programming. The bench also places the window over the bootstrap address after a second reset, to show that the window then takes over that address.

// File: rtl/cfgwin_io.sv
module cfgwin_io #(
  parameter int          WIN_LOG2  = 6,
  parameter logic [15:0] BOOT_PORT = 16'h02EA,
  parameter logic [7:0]  ID_BYTE   = 8'hA5,
  parameter logic [7:0]  REV_BYTE  = 8'h03
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        hit
);
  localparam int NDW   = 2 ** (WIN_LOG2 - 2);
  localparam int OFFW  = WIN_LOG2 - 2;
  localparam int SH    = 8 * int'(BOOT_PORT[1:0]);
  localparam logic [3:0]  BOOT_BE   = 4'(4'b0011 << BOOT_PORT[1:0]);
  localparam logic [31:0] BOOT_FILL = ~(32'h0000_FFFF << SH);

  logic        armed;
  logic [15:0] base;
  logic [31:0] store [NDW-1];
  logic [31:0] win_word;

  wire [OFFW-1:0] off = io_addr[WIN_LOG2-1:2];
  wire in_win   = armed && (io_addr[15:WIN_LOG2] == base[15:WIN_LOG2]);
  wire boot_dec = !armed && (io_addr[15:2] == BOOT_PORT[15:2]) && |(io_be & BOOT_BE);
  wire strobe   = io_rd || io_wr;
  wire [31:0] boot_word = (32'(base) << SH) | BOOT_FILL;
  wire [15:0] boot_val  = io_wdata[SH +: 16];

  assign hit      = strobe && (in_win || boot_dec);
  assign io_rdata = (hit && io_rd) ? (in_win ? win_word : boot_word) : '1;

  always_comb begin
    win_word = {base, REV_BYTE, ID_BYTE};
    for (int i = 0; i < NDW - 1; i++)
      if (off == OFFW'(i)) win_word = store[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      base  <= '0;
    end else if (io_wr && boot_dec && ((io_be & BOOT_BE) == BOOT_BE)) begin
      armed <= 1'b1;
      base  <= {boot_val[15:WIN_LOG2], {WIN_LOG2{1'b0}}};
    end
  end

  for (genvar i = 0; i < NDW - 1; i++) begin : g_dw
    for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst)
          store[i][8*b +: 8] <= '0;
        else if (io_wr && in_win && off == OFFW'(i) && io_be[b])
          store[i][8*b +: 8] <= io_wdata[8*b +: 8];
      end
    end
  end
endmodule

module cfgwin_io_chk #(
  parameter int          WIN_LOG2  = 6,
  parameter logic [15:0] BOOT_PORT = 16'h02EA,
  parameter logic [7:0]  ID_BYTE   = 8'hA5,
  parameter logic [7:0]  REV_BYTE  = 8'h03
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [31:0] io_rdata,
  input logic        hit,
  input logic        armed,
  input logic [15:0] base
);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !(io_rd || io_wr) |-> (!hit && io_rdata == '1));

  assert_miss_ones_R5: assert property (@(posedge clk) disable iff (rst)
    !hit |-> io_rdata == '1);

  assert_unarmed_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (!armed && io_addr[15:2] != BOOT_PORT[15:2]) |-> !hit);

  assert_base_align_R3: assert property (@(posedge clk) disable iff (rst)
    armed |-> base[WIN_LOG2-1:0] == '0);

  assert_write_once_R4: assert property (@(posedge clk) disable iff (rst)
    armed |=> (armed && $stable(base)));

  assert_id_dword_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && hit && io_rd && io_addr[WIN_LOG2-1:2] == '1)
      |-> io_rdata == {base, REV_BYTE, ID_BYTE});

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!armed && base == '0));
endmodule

bind cfgwin_io cfgwin_io_chk #(
  .WIN_LOG2(WIN_LOG2), .BOOT_PORT(BOOT_PORT), .ID_BYTE(ID_BYTE), .REV_BYTE(REV_BYTE)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_rdata(io_rdata), .hit(hit), .armed(armed), .base(base)
);

// File: tb/tb_cfgwin_io.sv
module tb_cfgwin_io;
  localparam logic [7:0] ID  = 8'h5C;
  localparam logic [7:0] REV = 8'h21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        hit;

  cfgwin_io #(.ID_BYTE(ID), .REV_BYTE(REV)) dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_be(io_be), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .hit(hit)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic        hit;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  task automatic access(input logic rd, input logic wr, input logic [15:0] a,
                        input logic [3:0] be, input logic [31:0] wd,
                        input logic eh, input logic [31:0] ed, input string tag);
    exp_t e;
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_be = be; io_wdata = wd;
    e.hit = eh; e.data = ed; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rd(input logic [15:0] a, input logic eh, input logic [31:0] ed, input string tag);
    access(1'b1, 1'b0, a, 4'hF, '0, eh, ed, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] wd,
                    input logic eh, input string tag);
    access(1'b0, 1'b1, a, be, wd, eh, 32'hFFFF_FFFF, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; io_rd = 1'b0; io_wr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  always begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (hit !== e.hit || io_rdata !== e.data) begin
        n_bad++;
        $display("FAIL %s: hit=%0b rdata=%h expected hit=%0b rdata=%h",
                 e.tag, hit, io_rdata, e.hit, e.data);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(16'h02E8, 1'b1, 32'h0000_FFFF, "R1 boot port after reset");
    rd(16'h1200, 1'b0, 32'hFFFF_FFFF, "R2 read before programming");
    wr(16'h1204, 4'hF, 32'hAAAA_5555, 1'b0, "R2 write before programming");
    wr(16'h02E8, 4'b0100, 32'h5678_0000, 1'b1, "R9 partial boot write");
    rd(16'h02E8, 1'b1, 32'h0000_FFFF, "R9 still unprogrammed");
    wr(16'h02E8, 4'b1100, 32'h1234_0000, 1'b1, "R3 program base");
    rd(16'h123C, 1'b1, {16'h1200, REV, ID}, "R3 R7 aligned base and id");
    wr(16'h02E8, 4'b1100, 32'h4000_0000, 1'b0, "R4 second boot write");
    rd(16'h02E8, 1'b0, 32'hFFFF_FFFF, "R4 boot port deaf");
    rd(16'h123C, 1'b1, {16'h1200, REV, ID}, "R4 base unchanged");
    rd(16'h1204, 1'b1, 32'h0, "R2 early write left no trace");
    wr(16'h1208, 4'hF, 32'hDEAD_BEEF, 1'b1, "R6 full write");
    rd(16'h1208, 1'b1, 32'hDEAD_BEEF, "R6 full readback");
    wr(16'h1208, 4'b0010, 32'h0000_5500, 1'b1, "R6 lane1 write");
    rd(16'h1208, 1'b1, 32'hDEAD_55EF, "R6 lane1 readback");
    wr(16'h1208, 4'b1000, 32'h1100_0000, 1'b1, "R6 lane3 write");
    rd(16'h1208, 1'b1, 32'h11AD_55EF, "R6 lane3 readback");
    wr(16'h1238, 4'hF, 32'hCAFE_F00D, 1'b1, "R6 top storage dword");
    rd(16'h1238, 1'b1, 32'hCAFE_F00D, "R6 top storage readback");
    rd(16'h1200, 1'b1, 32'h0, "R6 untouched dword");
    wr(16'h123C, 4'hF, 32'hFFFF_FFFF, 1'b1, "R7 write to id dword");
    rd(16'h123C, 1'b1, {16'h1200, REV, ID}, "R7 id dword unchanged");
    rd(16'h1240, 1'b0, 32'hFFFF_FFFF, "R5 above window");
    rd(16'h11FC, 1'b0, 32'hFFFF_FFFF, "R5 below window");
    access(1'b0, 1'b0, 16'h1208, 4'hF, '0, 1'b0, 32'hFFFF_FFFF, "R5 no strobe");
    do_reset();
    rd(16'h1208, 1'b0, 32'hFFFF_FFFF, "R8 window gone after reset");
    rd(16'h02E8, 1'b1, 32'h0000_FFFF, "R8 boot port back");
    wr(16'h02E8, 4'b1100, 32'h02C5_0000, 1'b1, "R8 reprogram");
    rd(16'h02C8, 1'b1, 32'h0, "R8 storage cleared");
    rd(16'h02E8, 1'b1, 32'h0, "R4 window covers boot address");
    wr(16'h02E8, 4'b1100, 32'h1234_0000, 1'b1, "R4 write lands in window");
    rd(16'h02E8, 1'b1, 32'h1234_0000, "R4 window storage readback");
    rd(16'h02FC, 1'b1, {16'h02C0, REV, ID}, "R4 base kept");
    access(1'b0, 1'b0, 16'h0, 4'h0, '0, 1'b0, 32'hFFFF_FFFF, "R5 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule